// File: doc/BRIEF.md
# Programmable Synchronous Memory Bus Controller

This block turns a simple valid/ready request port into command cycles on an external synchronous memory bus. The device on that bus may be a pipelined burst SRAM, a zero-bus-turnaround SRAM or a synchronous FIFO. Each accepted request becomes one command cycle carrying an address, byte enables and, for writes, 64-bit data. Returned read data comes back to the internal side as a one-cycle response pulse.

Four configuration inputs shape the bus timing:
- read latency, from command to data capture;
- write latency, from command to write data;
- whether chip enable is held while returned data is expected;
- whether the shared strobe pin is an address strobe followed by a deselect cycle, or a FIFO read enable without one.

The configuration is taken in only while the controller is idle. Requests of the same direction that arrive back to back form a burst of one command per clock. A change of direction, or a gap in requests, ends the burst. The controller then drains its pipelines before it accepts the next access. A turnaround cycle follows every read access.

Top module: `sync_mem_ctrl`

## Requirements
- R1: While reset is low, and after its release until the first request, `bus_ce_n`, `bus_strobe_n`, `bus_oe_n` and `bus_we_n` are 1. In the same period `bus_be_n` is all ones and `bus_dq_oe` and `rsp_valid` are 0. When idle after reset, `req_ready` is 1.
- R2: A read accepted at a clock edge drives its command in the next cycle t. In cycle t, `bus_ce_n` is 0, `bus_we_n` is 1 and `bus_be_n` is all zeros. Let L be `cfg_rd_lat` (1 to 3, with 0 treated as 1). `bus_oe_n` is 0 in cycle t+L. `bus_dq_i` is sampled at the end of cycle t+L and shows on `rsp_rdata` with `rsp_valid` high in cycle t+L+1.
- R3: A write accepted at a clock edge drives its command in cycle t. In cycle t, `bus_we_n` is 0 and `bus_be_n` equals the inverse of `req_be`. `req_wdata` is driven on `bus_dq_o`, with `bus_dq_oe` high, in cycle t+`cfg_wr_lat` (0 to 3).
- R4: Requests of the same direction accepted on consecutive edges give command cycles on consecutive clocks, each with its own `bus_addr` and byte enables.
- R5: With `cfg_ce_ext`=0, `bus_ce_n` is 0 only in command cycles. It is 1 in the cycle after the final command and during the read data window.
- R6: With `cfg_ce_ext`=1, `bus_ce_n` is also 0 in every cycle in which `bus_oe_n` is 0.
- R7: With `cfg_strobe_fifo`=0, `bus_strobe_n` is 0 in every command cycle. The cycle right after the final command of an access is a deselect cycle: `bus_strobe_n` 0, `bus_we_n` 1, `req_ready` 0, and `bus_ce_n` 1 when `cfg_ce_ext`=0.
- R8: With `cfg_strobe_fifo`=1, `bus_strobe_n` is 0 only in read command cycles, and no deselect cycle follows an access.
- R9: `bus_dq_oe` is never 1 in a cycle where `bus_oe_n` is 0, nor in the cycle that follows one.
- R10: A change of any configuration input during a burst does not alter that burst's timing. The change applies from the next access.
- R11: A request of the opposite direction ends a burst and sees `req_ready` 0 until both pipelines are empty and any turnaround cycle has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rd_lat | input | 2 | Read latency in cycles (0 treated as 1) |
| cfg_wr_lat | input | 2 | Write latency in cycles |
| cfg_ce_ext | input | 1 | 1: hold chip enable while output enable is active |
| cfg_strobe_fifo | input | 1 | 1: strobe pin is FIFO read enable, no deselect |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted at the edge when valid is also high |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 20 | Request address |
| req_be | input | 8 | Active-high byte enables for writes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle per beat |
| rsp_rdata | output | 64 | Read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_strobe_n | output | 1 | Address strobe or FIFO read enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_be_n | output | 8 | Byte enables, active low |
| bus_addr | output | 20 | Bus address |
| bus_dq_o | output | 64 | Data driven toward the device |
| bus_dq_oe | output | 1 | Drive enable for `bus_dq_o` |
| bus_dq_i | input | 64 | Data returned by the device |

## Verification
The main access path is exercised by a table of single accesses and bursts. Each entry uses a different mix of read and write latency, chip-enable hold and strobe role, and a burst length from one to four. Reads and writes at every latency step separate an off-by-one in either pipeline from a wrong tap selection. Pairing each strobe role with each chip-enable setting shows whether the deselect cycle and the chip-enable extension are decided independently. The directed cases cover:
- a read burst followed directly by a write, which shows the turnaround gap and the ready stall;
- a configuration change in the middle of a burst;
- a reset asserted while a burst is running.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_DRAIN = 2'd2,
    ST_TURN  = 2'd3
  } smc_state_e;

  typedef struct packed {
    logic [1:0] rd_lat;
    logic [1:0] wr_lat;
    logic       ce_ext;
    logic       strobe_fifo;
  } smc_cfg_t;

endpackage

// File: rtl/smc_rst_sync.sv
module smc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 64,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  smc_cfg_t          cfg_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              pipe_busy,
  output logic              req_ready,
  output smc_cfg_t          cfg_q,
  output logic              cmd_v,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BE_W-1:0]   cmd_be,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              desel_q
);
  smc_state_e state_q, state_n;
  logic       dir_q, dir_n;
  logic       desel_n;
  logic       accept;
  logic       cfg_en;

  // Ready: always when idle, mid-burst only for the same direction
  always_comb begin
    req_ready = 1'b0;
    case (state_q)
      ST_IDLE:  req_ready = 1'b1;
      ST_BURST: req_ready = (req_write == dir_q);
      default:  req_ready = 1'b0;
    endcase
  end

  assign accept = req_valid & req_ready;
  assign cfg_en = (state_q == ST_IDLE);

  always_comb begin
    state_n = state_q;
    dir_n   = dir_q;
    desel_n = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_n = ST_BURST;
          dir_n   = req_write;
        end
      end
      ST_BURST: begin
        if (!accept) begin
          state_n = ST_DRAIN;
          desel_n = ~cfg_q.strobe_fifo;
        end
      end
      ST_DRAIN: begin
        if (!desel_q && !pipe_busy) state_n = dir_q ? ST_IDLE : ST_TURN;
      end
      ST_TURN: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      desel_q <= 1'b0;
      cmd_v   <= 1'b0;
    end else begin
      state_q <= state_n;
      dir_q   <= dir_n;
      desel_q <= desel_n;
      cmd_v   <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_wr    <= 1'b0;
      cmd_addr  <= '0;
      cmd_be    <= '0;
      cmd_wdata <= '0;
    end else if (accept) begin
      cmd_wr    <= req_write;
      cmd_addr  <= req_addr;
      cmd_be    <= req_be;
      cmd_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/smc_rd_path.sv
module smc_rd_path #(
  parameter int DATA_W  = 64,
  parameter int LAT_W   = 2,
  localparam int MAX_LAT = (1 << LAT_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [LAT_W-1:0]  lat,
  input  logic [DATA_W-1:0] bus_dq_i,
  output logic              oe,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [MAX_LAT-1:0] pipe_q;
  logic [LAT_W-1:0]   lat_eff;

  assign lat_eff = (lat == '0) ? LAT_W'(1) : lat;
  assign oe      = pipe_q[lat_eff - LAT_W'(1)];
  assign busy    = |pipe_q;

  generate
    if (MAX_LAT > 1) begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[MAX_LAT-2:0], issue};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= issue;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= oe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rsp_rdata <= '0;
    else if (oe) rsp_rdata <= bus_dq_i;
  end
endmodule

// File: rtl/smc_wr_path.sv
module smc_wr_path #(
  parameter int DATA_W  = 64,
  parameter int LAT_W   = 2,
  localparam int MAX_LAT = (1 << LAT_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LAT_W-1:0]  lat,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_o,
  output logic              busy
);
  logic [MAX_LAT-1:0] stg_v;
  logic [DATA_W-1:0]  stg_d [MAX_LAT];

  genvar k;
  generate
    for (k = 0; k < MAX_LAT; k++) begin : g_stage
      logic              in_v;
      logic [DATA_W-1:0] in_d;
      if (k == 0) begin : g_head
        assign in_v = issue;
        assign in_d = wdata;
      end else begin : g_body
        assign in_v = stg_v[k-1];
        assign in_d = stg_d[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_v[k] <= 1'b0;
        else        stg_v[k] <= in_v;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    stg_d[k] <= '0;
        else if (in_v) stg_d[k] <= in_d;
      end
    end
  endgenerate

  always_comb begin
    if (lat == '0) begin
      dq_oe = issue;
      dq_o  = wdata;
    end else begin
      dq_oe = stg_v[lat - LAT_W'(1)];
      dq_o  = stg_d[lat - LAT_W'(1)];
    end
  end

  assign busy = |stg_v;
endmodule

// File: rtl/sync_mem_ctrl.sv
module sync_mem_ctrl
  import smc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 64,
  localparam int BE_W  = DATA_W / 8,
  localparam int LAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  cfg_rd_lat,
  input  logic [LAT_W-1:0]  cfg_wr_lat,
  input  logic              cfg_ce_ext,
  input  logic              cfg_strobe_fifo,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_ce_n,
  output logic              bus_strobe_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [BE_W-1:0]   bus_be_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe,
  input  logic [DATA_W-1:0] bus_dq_i
);
  logic              rst_i_n;
  smc_cfg_t          cfg_in, cfg_q;
  logic              cmd_v, cmd_wr, desel;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BE_W-1:0]   cmd_be;
  logic [DATA_W-1:0] cmd_wdata;
  logic              rd_oe, rd_busy, wr_busy;

  assign cfg_in = '{rd_lat: cfg_rd_lat, wr_lat: cfg_wr_lat,
                    ce_ext: cfg_ce_ext, strobe_fifo: cfg_strobe_fifo};

  smc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  smc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .cfg_in(cfg_in),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .pipe_busy(rd_busy | wr_busy),
    .req_ready(req_ready), .cfg_q(cfg_q), .cmd_v(cmd_v), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_be(cmd_be), .cmd_wdata(cmd_wdata),
    .desel_q(desel)
  );

  smc_rd_path #(.DATA_W(DATA_W), .LAT_W(LAT_W)) u_rd (
    .clk(clk), .rst_n(rst_i_n), .issue(cmd_v & ~cmd_wr),
    .lat(cfg_q.rd_lat), .bus_dq_i(bus_dq_i), .oe(rd_oe), .busy(rd_busy),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  smc_wr_path #(.DATA_W(DATA_W), .LAT_W(LAT_W)) u_wr (
    .clk(clk), .rst_n(rst_i_n), .issue(cmd_v & cmd_wr), .wdata(cmd_wdata),
    .lat(cfg_q.wr_lat), .dq_oe(bus_dq_oe), .dq_o(bus_dq_o), .busy(wr_busy)
  );

  // Bus strobes derived from registered command and pipeline state
  always_comb begin
    bus_ce_n = ~(cmd_v | (cfg_q.ce_ext & rd_oe));
    if (cfg_q.strobe_fifo) bus_strobe_n = ~(cmd_v & ~cmd_wr);
    else                   bus_strobe_n = ~(cmd_v | desel);
    bus_oe_n = ~rd_oe;
    bus_we_n = ~(cmd_v & cmd_wr);
    if (!cmd_v)     bus_be_n = '1;
    else if (cmd_wr) bus_be_n = ~cmd_be;
    else            bus_be_n = '0;
    bus_addr = cmd_addr;
  end
endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
  parameter int DATA_W = 64,
  localparam int BE_W  = DATA_W / 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            bus_ce_n,
  input logic            bus_strobe_n,
  input logic            bus_oe_n,
  input logic            bus_we_n,
  input logic [BE_W-1:0] bus_be_n,
  input logic            bus_dq_oe
);
  p_oe_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !bus_dq_oe);

  p_turn_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |=> !bus_dq_oe);

  p_be_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we_n |-> (bus_be_n == '0 || bus_be_n == '1));

  p_rsp_after_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!bus_oe_n));

  p_we_not_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> bus_oe_n);

  p_desel_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_strobe_n && bus_ce_n) |-> (!req_ready && bus_we_n));
endmodule

bind sync_mem_ctrl smc_checker #(.DATA_W(DATA_W)) u_smc_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_ce_n(bus_ce_n), .bus_strobe_n(bus_strobe_n), .bus_oe_n(bus_oe_n),
  .bus_we_n(bus_we_n), .bus_be_n(bus_be_n), .bus_dq_oe(bus_dq_oe)
);

// File: tb/test_sync_mem_ctrl.sv
`timescale 1ns/1ps
module test_sync_mem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_rd_lat, cfg_wr_lat;
  logic        cfg_ce_ext, cfg_strobe_fifo;
  logic        req_valid, req_ready, req_write;
  logic [19:0] req_addr;
  logic [7:0]  req_be;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        bus_ce_n, bus_strobe_n, bus_oe_n, bus_we_n, bus_dq_oe;
  logic [7:0]  bus_be_n;
  logic [19:0] bus_addr;
  logic [63:0] bus_dq_o, bus_dq_i;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign bus_dq_i = {32'hFEEDBEEF, cyc};

  sync_mem_ctrl i_sync_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat),
    .cfg_ce_ext(cfg_ce_ext), .cfg_strobe_fifo(cfg_strobe_fifo),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_ce_n(bus_ce_n),
    .bus_strobe_n(bus_strobe_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_be_n(bus_be_n), .bus_addr(bus_addr), .bus_dq_o(bus_dq_o),
    .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i)
  );

  typedef struct packed {
    logic        ce_n, st_n, oe_n, we_n, dq_oe, rv;
    logic [7:0]  be_n;
    logic [19:0] addr;
    logic [63:0] dq_o, rd;
  } tr_t;
  tr_t tr [1024];

  always @(negedge clk)
    tr[cyc[9:0]] = '{bus_ce_n, bus_strobe_n, bus_oe_n, bus_we_n, bus_dq_oe,
                     rsp_valid, bus_be_n, bus_addr, bus_dq_o, rsp_rdata};

  function automatic int ix(input int c);
    return c & 1023;
  endfunction

  function automatic logic [7:0] mk_be(input int b);
    return 8'hF0 ^ (8'h01 << b);
  endfunction

  function automatic logic [63:0] mk_wd(input logic [19:0] base, input int b);
    return {32'hC0DE0000 + 32'(b), 12'h0, base + 20'(b)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // One access (single beat or burst), then the checks computed from the requirements
  task automatic run_access(input logic [1:0] rl, input logic [1:0] wl,
                            input logic cex, input logic sfn, input logic wr,
                            input int beats, input logic [19:0] base,
                            input logic mid_chg);
    int cc [8];
    int L, W, cl;
    tr_t t;
    L = (rl == 2'd0) ? 1 : int'(rl);
    W = int'(wl);
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      if (b == 0) begin
        cfg_rd_lat = rl; cfg_wr_lat = wl; cfg_ce_ext = cex; cfg_strobe_fifo = sfn;
      end else if (b == 1 && mid_chg) begin
        cfg_rd_lat = 2'd3; cfg_wr_lat = 2'd0; cfg_ce_ext = ~cex; cfg_strobe_fifo = ~sfn;
      end
      req_valid = 1'b1; req_write = wr; req_addr = base + 20'(b);
      req_be = mk_be(b); req_wdata = mk_wd(base, b);
      #1;
      chk(req_ready === 1'b1, "R4 ready in burst", 64'(req_ready), 64'd1);
      cc[b] = cyc + 1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    for (int b = 0; b < beats; b++) begin
      t = tr[ix(cc[b])];
      chk(cc[b] == cc[0] + b, "R4 consecutive", 64'(cc[b]), 64'(cc[0] + b));
      chk(t.addr == base + 20'(b), "R4 addr", 64'(t.addr), 64'(base + 20'(b)));
      chk(t.ce_n == 1'b0, "R5 ce on command", 64'(t.ce_n), 64'd0);
      chk(t.we_n == ~wr, "R3 we on command", 64'(t.we_n), 64'(~wr));
      chk(t.be_n == (wr ? ~mk_be(b) : 8'h00), wr ? "R3 be" : "R2 be",
          64'(t.be_n), 64'(wr ? ~mk_be(b) : 8'h00));
      chk(t.st_n == (sfn ? wr : 1'b0), sfn ? "R8 strobe" : "R7 strobe",
          64'(t.st_n), 64'(sfn ? wr : 1'b0));
      if (wr) begin
        t = tr[ix(cc[b] + W)];
        chk(t.dq_oe && t.dq_o == mk_wd(base, b), mid_chg ? "R10 wdata" : "R3 wdata",
            t.dq_o, mk_wd(base, b));
      end else begin
        t = tr[ix(cc[b] + L)];
        chk(t.oe_n == 1'b0, mid_chg ? "R10 oe" : "R2 oe", 64'(t.oe_n), 64'd0);
        t = tr[ix(cc[b] + L + 1)];
        chk(t.rv && t.rd == {32'hFEEDBEEF, 32'(cc[b] + L)}, "R2 rdata",
            t.rd, {32'hFEEDBEEF, 32'(cc[b] + L)});
      end
    end
    cl = cc[beats-1];
    t = tr[ix(cl + 1)];
    if (!sfn) begin
      chk(t.st_n == 1'b0 && t.we_n == 1'b1, "R7 deselect", 64'({t.st_n, t.we_n}), 64'b01);
    end else begin
      chk(t.st_n == 1'b1, "R8 no deselect", 64'(t.st_n), 64'd1);
    end
    if (!cex) chk(t.ce_n == 1'b1, "R5 ce after last", 64'(t.ce_n), 64'd1);
    if (!wr) begin
      t = tr[ix(cl + L)];
      if (!cex) chk(t.ce_n == 1'b1, "R5 ce in data window", 64'(t.ce_n), 64'd1);
      else      chk(t.ce_n == 1'b0, "R6 ce held with oe", 64'(t.ce_n), 64'd0);
    end
  endtask

  // rd_lat, wr_lat, ce_ext, strobe_fifo, write, beats
  localparam logic [9:0] ROWS [8] = '{
    {2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd3},
    {2'd3, 2'd1, 1'b1, 1'b1, 1'b0, 3'd2},
    {2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 3'd4},
    {2'd1, 2'd3, 1'b0, 1'b1, 1'b1, 3'd2},
    {2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 3'd1},
    {2'd3, 2'd0, 1'b0, 1'b1, 1'b1, 3'd1},
    {2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 3'd4},
    {2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 3'd3}
  };

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int c0, c1, cw, co, n;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_be = '0; req_wdata = '0; cfg_rd_lat = 2'd1; cfg_wr_lat = 2'd0;
    cfg_ce_ext = 1'b0; cfg_strobe_fifo = 1'b0;
    repeat (3) @(negedge clk);
    chk({bus_ce_n, bus_strobe_n, bus_oe_n, bus_we_n} == 4'hF, "R1 strobes in reset",
        64'({bus_ce_n, bus_strobe_n, bus_oe_n, bus_we_n}), 64'hF);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({bus_ce_n, bus_strobe_n, bus_oe_n, bus_we_n} == 4'hF, "R1 strobes idle",
        64'({bus_ce_n, bus_strobe_n, bus_oe_n, bus_we_n}), 64'hF);
    chk(bus_be_n == 8'hFF && !bus_dq_oe && !rsp_valid, "R1 be/dq/rsp idle",
        64'({bus_be_n, bus_dq_oe, rsp_valid}), 64'h3FC);
    chk(req_ready === 1'b1, "R1 ready idle", 64'(req_ready), 64'd1);

    for (int i = 0; i < 8; i++)
      run_access(ROWS[i][9:8], ROWS[i][7:6], ROWS[i][5], ROWS[i][4], ROWS[i][3],
                 int'(ROWS[i][2:0]), 20'h01000 + 20'(i * 16), 1'b0);

    // R10: configuration changed mid-burst, for a write and for a read
    run_access(2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 3, 20'h02000, 1'b1);
    run_access(2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 3, 20'h02100, 1'b1);
    run_access(2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1, 20'h02200, 1'b0);

    // R11 / R9: read burst followed directly by a write request
    @(negedge clk);
    cfg_rd_lat = 2'd2; cfg_wr_lat = 2'd0; cfg_ce_ext = 1'b0; cfg_strobe_fifo = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00100;
    #1; c0 = cyc + 1;
    @(negedge clk);
    req_addr = 20'h00101;
    #1; c1 = cyc + 1;
    @(negedge clk);
    req_write = 1'b1; req_addr = 20'h00200; req_be = 8'hFF;
    req_wdata = 64'h1122334455667788;
    #1;
    chk(req_ready === 1'b0, "R11 ready low on direction change", 64'(req_ready), 64'd0);
    n = 0;
    while (req_ready !== 1'b1 && n < 40) begin
      @(negedge clk); #1; n++;
    end
    chk(n < 40, "R11 write eventually accepted", 64'(n), 64'd0);
    cw = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    co = c1 + 2;
    chk(c1 == c0 + 1, "R4 read burst", 64'(c1), 64'(c0 + 1));
    chk(tr[ix(co)].oe_n == 1'b0, "R2 last oe", 64'(tr[ix(co)].oe_n), 64'd0);
    chk(tr[ix(co + 1)].dq_oe == 1'b0, "R9 gap after oe", 64'(tr[ix(co + 1)].dq_oe), 64'd0);
    chk(cw >= co + 2, "R9 write after turnaround", 64'(cw), 64'(co + 2));
    chk(tr[ix(cw)].dq_oe && tr[ix(cw)].dq_o == 64'h1122334455667788, "R3 write after read",
        tr[ix(cw)].dq_o, 64'h1122334455667788);

    // R1: reset asserted while a read burst is running
    @(negedge clk);
    cfg_rd_lat = 2'd3; cfg_ce_ext = 1'b1; cfg_strobe_fifo = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00300;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk({bus_ce_n, bus_strobe_n, bus_oe_n, bus_we_n} == 4'hF, "R1 strobes on reset",
        64'({bus_ce_n, bus_strobe_n, bus_oe_n, bus_we_n}), 64'hF);
    chk(bus_be_n == 8'hFF && !bus_dq_oe && !rsp_valid, "R1 be/dq/rsp on reset",
        64'({bus_be_n, bus_dq_oe, rsp_valid}), 64'h3FC);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready === 1'b1 && bus_oe_n === 1'b1, "R1 idle after reset",
        64'({req_ready, bus_oe_n}), 64'b11);

    summary();
    $finish;
  end
endmodule